// File: doc/BRIEF.md
# Four-Entry Master Data Buffer

This block is the byte store that sits between a host register port and the transfer sequencer of a two-wire bus master. The host reaches it through one register location. A write appends a byte at the tail. A read takes the oldest byte from the head, and the remaining bytes move one place toward the head. At most four bytes are held. Two registered flags report whether the buffer holds anything and whether it is full.

A write to the mode-control register that has its flush bit (bit 6) set empties the buffer. When a receive transfer completes, the sequencer writes its bytes into the buffer in one step and sets the fill level directly. All outputs are registered. They change on the clock edge that accepts an operation and are visible during the following cycle.

Top module: `xfer_byte_queue`

## Requirements
- R1: After a synchronous reset, `fill_count` is 0, `has_data` and `full` are low, and `host_rdata` is 0xFF.
- R2: A host write (`host_sel`=1, `host_we`=1) with `fill_count` below 4 stores the byte behind the bytes already held and raises `fill_count` by one. A host write when `fill_count` is 4 is dropped: the count and the stored bytes stay as they were.
- R3: A host read (`host_sel`=1, `host_we`=0) with `fill_count` above 0 places the oldest byte on `host_rdata` after the edge, lowers `fill_count` by one and moves the remaining bytes up one place. Bytes therefore leave in the order they arrived.
- R4: A host read with `fill_count` equal to 0 puts 0xFF on `host_rdata` and changes neither the count nor the flags.
- R5: `has_data` is high exactly when `fill_count` is at least 1. A write into an empty buffer sets it, and a read of the last byte clears it.
- R6: `full` is high exactly when `fill_count` is 4. A write that brings the count to 4 sets it, and a read from a full buffer clears it.
- R7: A mode write (`mode_wr_en`=1) with bit 6 of `mode_wr_data` set empties the buffer: the count goes to 0, both flags clear and every entry is zeroed. A mode write with bit 6 clear has no effect on the buffer.
- R8: A sequencer load (`seq_load_en`=1) sets `fill_count` to `seq_count`, limited to 4. Entry i takes byte lane i of `seq_data` (bits 8i+7..8i) for every i below that count. `has_data` is set when the count is at least 1, and `full` is set when it is 4.
- R9: When operations coincide, a flush wins over a sequencer load, and a sequencer load wins over a host access. The losing host access is discarded completely: a discarded read leaves `host_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access to the buffer register this cycle |
| host_we | input | 1 | 1 = write (push), 0 = read (pop) |
| host_wdata | input | 8 | Byte to push |
| host_rdata | output | 8 | Byte from the last pop, 0xFF after a pop from an empty buffer |
| mode_wr_en | input | 1 | Host write to the mode-control register |
| mode_wr_data | input | 8 | Mode-control write value; bit 6 requests a flush |
| seq_load_en | input | 1 | Sequencer bulk load of received bytes |
| seq_count | input | 3 | Number of bytes received (values above 4 are limited to 4) |
| seq_data | input | 32 | Received bytes, lane i in bits 8i+7..8i |
| fill_count | output | 3 | Number of bytes held, 0 to 4 |
| has_data | output | 1 | Buffer holds at least one byte |
| full | output | 1 | Buffer holds four bytes |

## Verification
The collision that matters most is a sequencer load arriving in the same cycle as a host read. The bench drives both on one edge while the buffer holds known bytes. It then checks that the count and the following pops match the loaded bytes, and that `host_rdata` keeps the value it had before the edge. Flushes that coincide with loads or host writes are provoked in the same way, both in directed steps and throughout the random phase, and each result is judged against a reference model that applies the R9 priority order.

// File: rtl/xbq_pkg.sv
package xbq_pkg;
  // Operation chosen for the current cycle after priority resolution
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_FLUSH     = 3'd1,
    OP_LOAD      = 3'd2,
    OP_PUSH      = 3'd3,
    OP_POP       = 3'd4,
    OP_POP_EMPTY = 3'd5
  } xbq_op_e;
endpackage

// File: rtl/xbq_arbiter.sv
module xbq_arbiter
  import xbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             flush_req,
  input  logic             load_req,
  input  logic             host_sel,
  input  logic             host_we,
  input  logic [CNT_W-1:0] count,
  output xbq_op_e          op
);
  localparam logic [CNT_W-1:0] CntFull = CNT_W'(DEPTH);

  always_comb begin
    op = OP_IDLE;
    if (flush_req) begin
      op = OP_FLUSH;
    end else if (load_req) begin
      op = OP_LOAD;
    end else if (host_sel && host_we) begin
      op = (count < CntFull) ? OP_PUSH : OP_IDLE;
    end else if (host_sel) begin
      op = (count == '0) ? OP_POP_EMPTY : OP_POP;
    end
  end
endmodule

// File: rtl/xbq_index.sv
module xbq_index
  import xbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  xbq_op_e          op,
  input  logic [CNT_W-1:0] load_n,
  output logic [CNT_W-1:0] count,
  output logic             has_data,
  output logic             full
);
  localparam logic [CNT_W-1:0] CntFull = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CntOne  = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      has_data <= 1'b0;
      full     <= 1'b0;
    end else begin
      case (op)
        OP_FLUSH: begin
          count    <= '0;
          has_data <= 1'b0;
          full     <= 1'b0;
        end
        OP_LOAD: begin
          count    <= load_n;
          has_data <= (load_n != '0);
          full     <= (load_n == CntFull);
        end
        OP_PUSH: begin
          count    <= count + CntOne;
          has_data <= 1'b1;
          if (count == CntFull - CntOne) full <= 1'b1;
        end
        OP_POP: begin
          count <= count - CntOne;
          if (count == CntFull) full <= 1'b0;
          if (count == CntOne) has_data <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xbq_store.sv
module xbq_store
  import xbq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  xbq_op_e                 op,
  input  logic [CNT_W-1:0]        count,
  input  logic [CNT_W-1:0]        load_n,
  input  logic [DEPTH*DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata
);
  localparam logic [DATA_W-1:0] EmptyFill = {DATA_W{1'b1}};

  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lane
    logic [DATA_W-1:0] shift_src;
    if (i == DEPTH - 1) begin : g_tail
      assign shift_src = ent[i];
    end else begin : g_body
      assign shift_src = ent[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ent[i] <= '0;
      end else begin
        case (op)
          OP_FLUSH: ent[i] <= '0;
          OP_LOAD:  if (CNT_W'(i) < load_n) ent[i] <= load_data[i*DATA_W +: DATA_W];
          OP_PUSH:  if (count == CNT_W'(i)) ent[i] <= wdata;
          OP_POP:   ent[i] <= shift_src;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= EmptyFill;
    end else if (op == OP_POP) begin
      rdata <= ent[0];
    end else if (op == OP_POP_EMPTY) begin
      rdata <= EmptyFill;
    end
  end
endmodule

// File: rtl/xfer_byte_queue.sv
module xfer_byte_queue
  import xbq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int MODE_W    = 8,
  parameter int FLUSH_BIT = 6,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_sel,
  input  logic                    host_we,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  input  logic                    mode_wr_en,
  input  logic [MODE_W-1:0]       mode_wr_data,
  input  logic                    seq_load_en,
  input  logic [CNT_W-1:0]        seq_count,
  input  logic [DEPTH*DATA_W-1:0] seq_data,
  output logic [CNT_W-1:0]        fill_count,
  output logic                    has_data,
  output logic                    full
);
  localparam logic [CNT_W-1:0] CntFull = CNT_W'(DEPTH);

  logic             flush_req;
  logic             unused_mode_bits;
  logic [CNT_W-1:0] load_n;
  xbq_op_e          op;

  assign flush_req        = mode_wr_en && mode_wr_data[FLUSH_BIT];
  assign unused_mode_bits = ^mode_wr_data;
  assign load_n           = (seq_count > CntFull) ? CntFull : seq_count;

  xbq_arbiter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_arb (
    .flush_req (flush_req),
    .load_req  (seq_load_en),
    .host_sel  (host_sel),
    .host_we   (host_we),
    .count     (fill_count),
    .op        (op)
  );

  xbq_index #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_idx (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_n   (load_n),
    .count    (fill_count),
    .has_data (has_data),
    .full     (full)
  );

  xbq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .count     (fill_count),
    .load_n    (load_n),
    .load_data (seq_data),
    .wdata     (host_wdata),
    .rdata     (host_rdata)
  );
endmodule

// File: rtl/xbq_checker.sv
module xbq_checker #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int MODE_W    = 8,
  parameter int FLUSH_BIT = 6,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel,
  input logic              host_we,
  input logic [DATA_W-1:0] host_rdata,
  input logic              mode_wr_en,
  input logic [MODE_W-1:0] mode_wr_data,
  input logic              seq_load_en,
  input logic [CNT_W-1:0]  seq_count,
  input logic [CNT_W-1:0]  fill_count,
  input logic              has_data,
  input logic              full
);
  localparam logic [CNT_W-1:0] CntFull = CNT_W'(DEPTH);

  logic fl;
  assign fl = mode_wr_en && mode_wr_data[FLUSH_BIT];

  // R5
  has_data_flag_chk: assert property (@(posedge clk) disable iff (rst)
    has_data == (fill_count != '0));

  // R6
  full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    full == (fill_count == CntFull));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl && !seq_load_en && host_sel && host_we && fill_count == CntFull)
      |=> fill_count == CntFull);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl && !seq_load_en && host_sel && !host_we && fill_count == '0)
      |=> (fill_count == '0 && host_rdata == {DATA_W{1'b1}}));

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    fl |=> (fill_count == '0 && !has_data && !full));

  // R8
  load_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl && seq_load_en && seq_count <= CntFull) |=> fill_count == $past(seq_count));

  // R9
  load_beats_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl && seq_load_en && host_sel && !host_we) |=> $stable(host_rdata));
endmodule

bind xfer_byte_queue xbq_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .MODE_W(MODE_W), .FLUSH_BIT(FLUSH_BIT), .CNT_W(CNT_W)
) u_xbq_chk (
  .clk          (clk),
  .rst          (rst),
  .host_sel     (host_sel),
  .host_we      (host_we),
  .host_rdata   (host_rdata),
  .mode_wr_en   (mode_wr_en),
  .mode_wr_data (mode_wr_data),
  .seq_load_en  (seq_load_en),
  .seq_count    (seq_count),
  .fill_count   (fill_count),
  .has_data     (has_data),
  .full         (full)
);

// File: tb/xfer_byte_queue_test.sv
module xfer_byte_queue_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        mode_wr_en = 1'b0;
  logic [7:0]  mode_wr_data = 8'h00;
  logic        seq_load_en = 1'b0;
  logic [2:0]  seq_count = 3'd0;
  logic [31:0] seq_data = 32'h0;
  logic [2:0]  fill_count;
  logic        has_data;
  logic        full;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_ent [4];
  int         m_cnt;
  logic [7:0] m_rd;

  always #4 clk = ~clk;

  xfer_byte_queue uut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .seq_load_en(seq_load_en), .seq_count(seq_count), .seq_data(seq_data),
    .fill_count(fill_count), .has_data(has_data), .full(full)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference update from the requirements, priority per R9
  task automatic model_step(input bit fl, input bit ld, input int lc, input logic [31:0] ldat,
                            input bit sel, input bit we, input logic [7:0] wd);
    if (fl) begin
      m_cnt = 0;
      for (int i = 0; i < 4; i++) m_ent[i] = 8'h00;
    end else if (ld) begin
      m_cnt = (lc > 4) ? 4 : lc;
      for (int i = 0; i < m_cnt; i++) m_ent[i] = ldat[i*8 +: 8];
    end else if (sel && we) begin
      if (m_cnt < 4) begin
        m_ent[m_cnt] = wd;
        m_cnt++;
      end
    end else if (sel) begin
      if (m_cnt == 0) m_rd = 8'hFF;
      else begin
        m_rd = m_ent[0];
        for (int i = 0; i < 3; i++) m_ent[i] = m_ent[i+1];
        m_cnt--;
      end
    end
  endtask

  task automatic step(input string req, input bit men, input logic [7:0] mdat, input bit ld,
                      input int lc, input logic [31:0] ldat, input bit sel, input bit we,
                      input logic [7:0] wd);
    @(negedge clk);
    mode_wr_en = men; mode_wr_data = mdat;
    seq_load_en = ld; seq_count = 3'(lc); seq_data = ldat;
    host_sel = sel; host_we = we; host_wdata = wd;
    model_step(men && mdat[6], ld, lc, ldat, sel, we, wd);
    @(posedge clk);
    #1;
    mode_wr_en = 1'b0; seq_load_en = 1'b0; host_sel = 1'b0;
    chk({req, " count"}, int'(fill_count), m_cnt);
    chk({req, " has_data"}, int'(has_data), int'(m_cnt != 0));
    chk({req, " full"}, int'(full), int'(m_cnt == 4));
    chk({req, " rdata"}, int'(host_rdata), int'(m_rd));
  endtask

  task automatic push(input string req, input logic [7:0] b);
    step(req, 0, 8'h00, 0, 0, 32'h0, 1, 1, b);
  endtask

  task automatic pop(input string req);
    step(req, 0, 8'h00, 0, 0, 32'h0, 1, 0, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_rd = 8'hFF;
    for (int i = 0; i < 4; i++) m_ent[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", int'(fill_count), 0);
    chk("R1 has_data", int'(has_data), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 rdata", int'(host_rdata), 8'hFF);

    // R4 empty pop
    pop("R4 empty pop");
    // R2 R5 R6 fill to full, then an overflow write
    push("R5 first push", 8'h11);
    push("R2 push", 8'h22);
    push("R2 push", 8'h33);
    push("R6 push to full", 8'h44);
    push("R2 dropped write", 8'h99);
    // R3 R6 R5 drain in order
    pop("R6 pop from full");
    pop("R3 pop order");
    pop("R3 pop order");
    pop("R5 pop last");
    pop("R4 empty pop again");
    // R9 load together with pop
    push("R2 push", 8'hA1);
    push("R2 push", 8'hA2);
    step("R9 load beats pop", 0, 8'h00, 1, 2, 32'hDDCC_BBAA, 1, 0, 8'h00);
    pop("R8 loaded lane0");
    pop("R8 loaded lane1");
    // R8 clamp and zero
    step("R8 load clamp", 0, 8'h00, 1, 7, 32'h4433_2211, 0, 0, 8'h00);
    step("R8 load zero", 0, 8'h00, 1, 0, 32'h0, 0, 0, 8'h00);
    // R7 flush and no-op mode write
    push("R2 push", 8'h5A);
    step("R7 mode write no flush", 1, 8'hBF, 0, 0, 32'h0, 0, 0, 8'h00);
    step("R9 flush beats load and push", 1, 8'h40, 1, 3, 32'h0102_0304, 1, 1, 8'h77);
    pop("R7 pop after flush");

    // Random phase
    for (int n = 0; n < 400; n++) begin
      automatic int r = int'($urandom_range(0, 99));
      automatic bit men = (r < 6);
      automatic logic [7:0] md = 8'($urandom);
      automatic bit ld = (r >= 6 && r < 16) || (r % 17 == 0);
      automatic int lc = int'($urandom_range(0, 7));
      automatic logic [31:0] ldat = $urandom;
      automatic bit sel = ($urandom_range(0, 3) != 0);
      automatic bit we = $urandom_range(0, 1) == 1;
      step("R9 random mix", men, md, ld, lc, ldat, sel, we, 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule